// File: doc/BRIEF.md
# CSR Access Executor

This block carries out the six control-status-register access operations of a 32-bit integer core: swap, bit-set and bit-clear, each taking its source either from an integer register or from a 5-bit immediate held in the source-index field. It receives a decoded instruction word, the source operand value, and the current contents, writable-bit mask and read-only indication of the addressed register from an external register file.

It then decides whether the register is read, whether a write is attempted, and whether that write is illegal. A read or write is suppressed by looking at the register index (x0) or at the immediate field, never at the value of an operand. The CSR address and read enable are produced in the same cycle as the instruction. The write request, the destination-register writeback and the illegal-instruction flag come out one clock later from a register stage.

Top module: `csr_op_unit`

## Requirements
- R1: After a synchronous active-high reset, `done_o`, `csr_we_o`, `rd_we_o` and `illegal_o` are all low.
- R2: Swap (funct3 001 with register source, 101 with immediate source) writes the old CSR value to rd and writes the source to the CSR. Only bits set in `csr_wmask_i` take the source value; the other bits keep their old value.
- R3: A swap whose rd index is 0 keeps `csr_re_o` low and does not write rd, but the CSR write still happens.
- R4: Set (funct3 010 and 110) writes old | (source & writable mask) to the CSR and writes the old value to rd.
- R5: Clear (funct3 011 and 111) writes old & ~(source & writable mask) to the CSR and writes the old value to rd.
- R6: For register set or clear with source index 0 (instr[19:15] = 0), `csr_we_o` stays low and `illegal_o` stays low, even for a read-only CSR, while the read and the rd writeback still happen.
- R7: For register set or clear whose source index is not 0 but whose operand value is 0, a write of the unchanged value is still issued. If the CSR is read-only, the illegal flag is raised.
- R8: The immediate forms take instr[19:15] as an unsigned value, zero-extended to 32 bits.
- R9: Immediate set or clear with a zero immediate issues no CSR write.
- R10: An attempted write to a read-only CSR (address bits [11:10] = 2'b11, or `csr_ro_i` high) raises `illegal_o`, and both `csr_we_o` and `rd_we_o` stay low.
- R11: An instruction whose opcode is not SYSTEM (7'b1110011), or whose funct3 is 000 or 100, raises no read enable, no write, no rd writeback, no `done_o` and no illegal flag.
- R12: `csr_addr_o` and `csr_re_o` respond in the same cycle as the instruction. `done_o` and all write, writeback and fault outputs appear on the clock edge after the one that samples the instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Instruction present this cycle |
| instr_i | input | 32 | Instruction word |
| rs1_val_i | input | 32 | Value of the source integer register |
| csr_rdata_i | input | 32 | Current contents of the addressed CSR |
| csr_wmask_i | input | 32 | Writable bits of the addressed CSR |
| csr_ro_i | input | 1 | Addressed CSR is read-only |
| csr_addr_o | output | 12 | CSR address, combinational |
| csr_re_o | output | 1 | CSR read with side effects, combinational |
| done_o | output | 1 | A CSR operation completed |
| csr_we_o | output | 1 | CSR write enable |
| csr_waddr_o | output | 12 | CSR write address |
| csr_wdata_o | output | 32 | CSR write data |
| rd_we_o | output | 1 | Integer register writeback enable |
| rd_idx_o | output | 5 | Integer register writeback index |
| rd_wdata_o | output | 32 | Integer register writeback value |
| illegal_o | output | 1 | Illegal-instruction fault |

## Verification
The read enable and CSR address are due in the same cycle as the instruction, so the bench checks them one nanosecond after it drives the inputs on the falling edge. Every other result is due one rising edge later. For each instruction the driver pushes a predicted item into a queue, and the monitor pops that item on the next falling edge, after the register stage has updated. The monitor then compares it with the outputs. Because each issued instruction produces exactly one item and exactly one pop, a result that arrives a cycle early or late shows up as a mismatch.

// File: rtl/csr_op_pkg.sv
package csr_op_pkg;
  localparam int ILEN      = 32;
  localparam int CSR_AW    = 12;
  localparam int REG_IW    = 5;
  localparam logic [6:0] OPC_SYSTEM = 7'b1110011;

  typedef enum logic [1:0] {
    K_NONE = 2'b00,
    K_SWAP = 2'b01,
    K_SET  = 2'b10,
    K_CLR  = 2'b11
  } csr_kind_e;

  typedef struct packed {
    logic              hit;
    csr_kind_e         kind;
    logic              use_imm;
    logic [CSR_AW-1:0] addr;
    logic [REG_IW-1:0] src_idx;
    logic [REG_IW-1:0] rd_idx;
  } csr_dec_t;
endpackage

// File: rtl/csr_op_decode.sv
module csr_op_decode
  import csr_op_pkg::*;
(
  input  logic            valid_i,
  input  logic [ILEN-1:0] instr_i,
  output csr_dec_t        dec_o
);
  logic [2:0] f3;
  logic       opc_ok;

  always_comb begin
    f3     = instr_i[14:12];
    opc_ok = (instr_i[6:0] == OPC_SYSTEM);
    dec_o.kind    = csr_kind_e'(f3[1:0]);
    dec_o.use_imm = f3[2];
    dec_o.hit     = valid_i && opc_ok && (f3[1:0] != 2'b00);
    dec_o.addr    = instr_i[31:20];
    dec_o.src_idx = instr_i[19:15];
    dec_o.rd_idx  = instr_i[11:7];
  end
endmodule

// File: rtl/csr_op_policy.sv
module csr_op_policy
  import csr_op_pkg::*;
(
  input  csr_dec_t dec_i,
  input  logic     ro_ext_i,
  output logic     rd_csr_o,
  output logic     wr_try_o,
  output logic     fault_o,
  output logic     rd_wb_o
);
  logic ro_space;

  always_comb begin
    ro_space = (dec_i.addr[CSR_AW-1:CSR_AW-2] == 2'b11) || ro_ext_i;
    // swap skips the read when rd is x0; set/clear always read
    rd_csr_o = dec_i.hit && ((dec_i.kind != K_SWAP) || (dec_i.rd_idx != '0));
    // set/clear skip the write when the source index (or immediate) is zero
    wr_try_o = dec_i.hit && ((dec_i.kind == K_SWAP) || (dec_i.src_idx != '0));
    fault_o  = wr_try_o && ro_space;
    rd_wb_o  = rd_csr_o && !fault_o && (dec_i.rd_idx != '0);
  end
endmodule

// File: rtl/csr_op_alu.sv
module csr_op_alu
  import csr_op_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  csr_kind_e       kind_i,
  input  logic [XLEN-1:0] old_i,
  input  logic [XLEN-1:0] src_i,
  input  logic [XLEN-1:0] wmask_i,
  output logic [XLEN-1:0] new_o
);
  logic [XLEN-1:0] eff;

  always_comb begin
    eff = src_i & wmask_i;
    unique case (kind_i)
      K_SWAP:  new_o = (old_i & ~wmask_i) | eff;
      K_SET:   new_o = old_i | eff;
      K_CLR:   new_o = old_i & ~eff;
      default: new_o = old_i;
    endcase
  end
endmodule

// File: rtl/csr_op_unit.sv
module csr_op_unit
  import csr_op_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid_i,
  input  logic [ILEN-1:0]   instr_i,
  input  logic [XLEN-1:0]   rs1_val_i,
  input  logic [XLEN-1:0]   csr_rdata_i,
  input  logic [XLEN-1:0]   csr_wmask_i,
  input  logic              csr_ro_i,
  output logic [CSR_AW-1:0] csr_addr_o,
  output logic              csr_re_o,
  output logic              done_o,
  output logic              csr_we_o,
  output logic [CSR_AW-1:0] csr_waddr_o,
  output logic [XLEN-1:0]   csr_wdata_o,
  output logic              rd_we_o,
  output logic [REG_IW-1:0] rd_idx_o,
  output logic [XLEN-1:0]   rd_wdata_o,
  output logic              illegal_o
);
  localparam int PAD_W = XLEN - REG_IW;

  csr_dec_t        dec;
  logic            rd_csr, wr_try, fault, rd_wb;
  logic [XLEN-1:0] src, new_val;

  csr_op_decode u_dec (
    .valid_i (in_valid_i),
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  csr_op_policy u_pol (
    .dec_i    (dec),
    .ro_ext_i (csr_ro_i),
    .rd_csr_o (rd_csr),
    .wr_try_o (wr_try),
    .fault_o  (fault),
    .rd_wb_o  (rd_wb)
  );

  always_comb begin
    src = dec.use_imm ? {{PAD_W{1'b0}}, dec.src_idx} : rs1_val_i;
  end

  csr_op_alu #(.XLEN(XLEN)) u_alu (
    .kind_i  (dec.kind),
    .old_i   (csr_rdata_i),
    .src_i   (src),
    .wmask_i (csr_wmask_i),
    .new_o   (new_val)
  );

  assign csr_addr_o = dec.addr;
  assign csr_re_o   = rd_csr;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o      <= 1'b0;
      csr_we_o    <= 1'b0;
      csr_waddr_o <= '0;
      csr_wdata_o <= '0;
      rd_we_o     <= 1'b0;
      rd_idx_o    <= '0;
      rd_wdata_o  <= '0;
      illegal_o   <= 1'b0;
    end else begin
      done_o      <= dec.hit;
      csr_we_o    <= wr_try && !fault;
      csr_waddr_o <= dec.addr;
      csr_wdata_o <= new_val;
      rd_we_o     <= rd_wb;
      rd_idx_o    <= dec.rd_idx;
      rd_wdata_o  <= csr_rdata_i;
      illegal_o   <= fault;
    end
  end
endmodule

// File: rtl/csr_op_unit_chk.sv
module csr_op_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid_i,
  input logic [31:0] instr_i,
  input logic        csr_re_o,
  input logic        done_o,
  input logic        csr_we_o,
  input logic        rd_we_o,
  input logic [4:0]  rd_idx_o,
  input logic        illegal_o
);
  logic sys_op;
  assign sys_op = in_valid_i && (instr_i[6:0] == 7'b1110011) && (instr_i[13:12] != 2'b00);

  p_fault_blocks_we_r10: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> !csr_we_o && !rd_we_o);

  p_no_x0_wb_r3: assert property (@(posedge clk) disable iff (rst)
    rd_we_o |-> rd_idx_o != 5'd0);

  p_re_needs_op_r11: assert property (@(posedge clk) disable iff (rst)
    csr_re_o |-> sys_op);

  p_swap_x0_noread_r3: assert property (@(posedge clk) disable iff (rst)
    (sys_op && instr_i[13:12] == 2'b01 && instr_i[11:7] == 5'd0) |-> !csr_re_o);

  p_done_latency_r12: assert property (@(posedge clk) disable iff (rst)
    sys_op |=> done_o);

  p_zero_src_nowrite_r6: assert property (@(posedge clk) disable iff (rst)
    (sys_op && instr_i[13:12] != 2'b01 && instr_i[19:15] == 5'd0) |=> !csr_we_o && !illegal_o);

  p_imm_zero_nowrite_r9: assert property (@(posedge clk) disable iff (rst)
    (sys_op && instr_i[14] && instr_i[13:12] != 2'b01 && instr_i[19:15] == 5'd0) |=> !csr_we_o);
endmodule

bind csr_op_unit csr_op_unit_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid_i (in_valid_i),
  .instr_i    (instr_i),
  .csr_re_o   (csr_re_o),
  .done_o     (done_o),
  .csr_we_o   (csr_we_o),
  .rd_we_o    (rd_we_o),
  .rd_idx_o   (rd_idx_o),
  .illegal_o  (illegal_o)
);

// File: tb/csr_op_unit_tb.sv
`timescale 1ns/1ps
module csr_op_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [31:0] rs1_val_i = '0;
  logic [31:0] csr_rdata_i = '0;
  logic [31:0] csr_wmask_i = '0;
  logic        csr_ro_i = 1'b0;
  logic [11:0] csr_addr_o;
  logic        csr_re_o;
  logic        done_o;
  logic        csr_we_o;
  logic [11:0] csr_waddr_o;
  logic [31:0] csr_wdata_o;
  logic        rd_we_o;
  logic [4:0]  rd_idx_o;
  logic [31:0] rd_wdata_o;
  logic        illegal_o;

  csr_op_unit u_dut (.*);

  always #4 clk = ~clk;

  typedef struct {
    logic        done, we, rdwe, ill;
    logic [11:0] waddr;
    logic [31:0] wdata, rdata;
    logic [4:0]  rdi;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [6:0] opc, input logic [2:0] f3, input logic [11:0] addr,
                       input logic [4:0] sidx, input logic [4:0] rd, input logic [31:0] rs1v,
                       input logic [31:0] old, input logic [31:0] wm, input logic ro,
                       input string tag);
    logic [1:0]  kind;
    logic        hit, re, wtry, ill;
    logic [31:0] src, eff, nv;
    exp_t e;
    @(negedge clk);
    in_valid_i  = 1'b1;
    instr_i     = {addr, sidx, f3, rd, opc};
    rs1_val_i   = rs1v;
    csr_rdata_i = old;
    csr_wmask_i = wm;
    csr_ro_i    = ro;
    kind = f3[1:0];
    hit  = (opc == 7'b1110011) && (kind != 2'b00);
    re   = hit && (kind != 2'b01 || rd != 0);
    wtry = hit && (kind == 2'b01 || sidx != 0);
    ill  = wtry && (addr[11:10] == 2'b11 || ro);
    src  = f3[2] ? {27'd0, sidx} : rs1v;
    eff  = src & wm;
    case (kind)
      2'b01:   nv = (old & ~wm) | eff;
      2'b10:   nv = old | eff;
      2'b11:   nv = old & ~eff;
      default: nv = old;
    endcase
    e.done = hit; e.we = wtry && !ill; e.ill = ill;
    e.rdwe = re && !ill && rd != 0;
    e.waddr = addr; e.wdata = nv; e.rdata = old; e.rdi = rd; e.tag = tag;
    #1;
    chk(csr_re_o === re, {tag, " R12 read enable"}, {31'd0, csr_re_o}, {31'd0, re});
    if (hit) chk(csr_addr_o === addr, {tag, " R12 address"}, {20'd0, csr_addr_o}, {20'd0, addr});
    exp_q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (!rst && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk(done_o === e.done, {e.tag, " done"}, {31'd0, done_o}, {31'd0, e.done});
      chk(csr_we_o === e.we, {e.tag, " csr we"}, {31'd0, csr_we_o}, {31'd0, e.we});
      chk(illegal_o === e.ill, {e.tag, " illegal"}, {31'd0, illegal_o}, {31'd0, e.ill});
      chk(rd_we_o === e.rdwe, {e.tag, " rd we"}, {31'd0, rd_we_o}, {31'd0, e.rdwe});
      if (e.we) begin
        chk(csr_wdata_o === e.wdata, {e.tag, " csr wdata"}, csr_wdata_o, e.wdata);
        chk(csr_waddr_o === e.waddr, {e.tag, " csr waddr"}, {20'd0, csr_waddr_o}, {20'd0, e.waddr});
      end
      if (e.rdwe) begin
        chk(rd_wdata_o === e.rdata, {e.tag, " rd data"}, rd_wdata_o, e.rdata);
        chk(rd_idx_o === e.rdi, {e.tag, " rd idx"}, {27'd0, rd_idx_o}, {27'd0, e.rdi});
      end
    end
  end

  localparam logic [6:0] SYS = 7'b1110011;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(done_o === 0 && csr_we_o === 0 && rd_we_o === 0 && illegal_o === 0, "R1 reset outputs",
        {28'd0, done_o, csr_we_o, rd_we_o, illegal_o}, 32'd0);
    rst = 1'b0;

    issue(SYS, 3'b001, 12'h340, 5'd3, 5'd5, 32'h1234_5678, 32'hA5A5_0F0F, 32'hFFFF_FFFF, 0, "R2 swap full");
    issue(SYS, 3'b001, 12'h341, 5'd3, 5'd6, 32'h1234_5678, 32'hA5A5_0F0F, 32'h0000_FFFF, 0, "R2 swap masked");
    issue(SYS, 3'b001, 12'h342, 5'd4, 5'd0, 32'hDEAD_BEEF, 32'h0000_0001, 32'hFFFF_FFFF, 0, "R3 swap rd x0");
    issue(SYS, 3'b010, 12'h300, 5'd7, 5'd8, 32'h0F0F_0001, 32'h0000_00F0, 32'hFFFF_FFFE, 0, "R4 set");
    issue(SYS, 3'b011, 12'h300, 5'd7, 5'd9, 32'h0000_00FF, 32'hFFFF_0F0F, 32'h0000_FFF0, 0, "R5 clear");
    issue(SYS, 3'b010, 12'hC00, 5'd0, 5'd10, 32'hFFFF_FFFF, 32'h0000_1234, 32'hFFFF_FFFF, 0, "R6 set x0 ro");
    issue(SYS, 3'b011, 12'h305, 5'd0, 5'd11, 32'hFFFF_FFFF, 32'h0000_5555, 32'hFFFF_FFFF, 0, "R6 clear x0");
    issue(SYS, 3'b011, 12'h305, 5'd5, 5'd12, 32'h0000_0000, 32'h0000_5555, 32'hFFFF_FFFF, 0, "R7 zero value write");
    issue(SYS, 3'b010, 12'hC01, 5'd5, 5'd12, 32'h0000_0000, 32'h0000_5555, 32'hFFFF_FFFF, 0, "R7 R10 zero value ro");
    issue(SYS, 3'b101, 12'h344, 5'h1F, 5'd13, 32'hFFFF_FFFF, 32'hABCD_0000, 32'hFFFF_FFFF, 0, "R8 swap imm");
    issue(SYS, 3'b111, 12'h344, 5'd3, 5'd14, 32'h0, 32'h0000_00FF, 32'hFFFF_FFFF, 0, "R8 clear imm");
    issue(SYS, 3'b110, 12'h344, 5'd0, 5'd15, 32'hFFFF_FFFF, 32'h0000_0010, 32'hFFFF_FFFF, 0, "R9 set imm zero");
    issue(SYS, 3'b111, 12'hC02, 5'd0, 5'd16, 32'hFFFF_FFFF, 32'h0000_0010, 32'hFFFF_FFFF, 0, "R9 clear imm zero ro");
    issue(SYS, 3'b001, 12'h300, 5'd2, 5'd17, 32'h1111_1111, 32'h2222_2222, 32'hFFFF_FFFF, 1, "R10 swap ro input");
    issue(SYS, 3'b101, 12'hC80, 5'd1, 5'd0, 32'h0, 32'h2222_2222, 32'hFFFF_FFFF, 0, "R10 swapi ro space");
    issue(SYS, 3'b000, 12'h300, 5'd2, 5'd18, 32'h1, 32'h2, 32'hFFFF_FFFF, 0, "R11 funct3 000");
    issue(SYS, 3'b100, 12'h300, 5'd2, 5'd18, 32'h1, 32'h2, 32'hFFFF_FFFF, 0, "R11 funct3 100");
    issue(7'b0110011, 3'b001, 12'h300, 5'd2, 5'd18, 32'h1, 32'h2, 32'hFFFF_FFFF, 0, "R11 wrong opcode");
    issue(SYS, 3'b010, 12'h7C0, 5'd9, 5'd19, 32'h8000_0000, 32'h0000_0003, 32'hFFFF_FFFF, 0, "R4 R12 back to back");
    @(negedge clk);
    in_valid_i = 1'b0;
    #1;
    chk(csr_re_o === 1'b0, "R11 idle read enable", {31'd0, csr_re_o}, 32'd0);
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule